// File: doc/BRIEF.md
# Power-Gated Packet Buffer Controller

This block sits in front of a 64 kbit packet buffer made of eight independently powered banks with binary-weighted sizes. When a packet header arrives, the controller takes the payload length in bytes and switches on the smallest address-contiguous group of banks that can hold it. Every other bank is switched off, so that during long sleep periods only the storage in use leaks. Powering always starts from the smallest bank and grows towards the largest, so a larger packet switches on more banks. A smaller packet switches off the largest banks first.

Word accesses (32-bit words, 2048 words in total) go through the controller. It steers each access to the owning bank. An access to a switched-off bank returns zero and is flagged. An access to a bank that has just been switched on is held off until the bank has woken up. The storage array is a behavioural model and keeps its contents while a bank is off.

Top module: `pgbuf_ctrl`

## Requirements
- R1: After reset, `bank_pwr_en` is 0x01 and `len_ovf`, `rd_valid` and `acc_err` are 0.
- R2: Bit k of `bank_pwr_en` powers bank k. Bank 0 and bank 1 hold 512 bit each, and bank k (k ≥ 2) holds 2^(k-1)·512 bit. On the clock edge where `hdr_valid` is high, the mask becomes (2^n)-1, where n is the smallest count from 1 to 8 with 64·2^(n-1) ≥ `hdr_len` bytes.
- R3: A length of 0 enables only bank 0. Bank 0 is never switched off.
- R4: A length above 8192 bytes enables all banks (0xFF) and sets `len_ovf`. A length of 8192 or less clears it. The flag holds until the next header.
- R5: Word address a belongs to bank 0 when a < 16, and to bank k when 16·2^(k-1) ≤ a < 16·2^k.
- R6: An accepted read returns, one cycle later, the last word written to that address, with `rd_valid` high for one cycle. An access is accepted when `acc_valid` and `acc_ready` are both high.
- R7: An accepted access to a switched-off bank raises `acc_err` one cycle later. For a read, `rd_data` is zero. A write does not change the stored word.
- R8: When a header switches a bank on, `acc_ready` is low for accesses to that bank for exactly two cycles after that edge. Banks that were already on stay ready.
- R9: Accesses to powered banks never raise `acc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header length strobe |
| hdr_len | input | 16 | Payload length in bytes |
| acc_valid | input | 1 | Access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 11 | Word address |
| acc_wdata | input | 32 | Write data |
| acc_ready | output | 1 | Low while the addressed bank is waking |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| acc_err | output | 1 | Previous accepted access hit an off bank |
| bank_pwr_en | output | 8 | Per-bank power enable |
| len_ovf | output | 1 | Last header exceeded the capacity |

## Verification
The mask and the overflow flag change on the edge that samples `hdr_valid`. The bench drives inputs on falling edges and reads these outputs at the following falling edge. Read data and the error flag are registered once, so they are read half a cycle after the accepting edge. The wake-up stall is probed at the two falling edges that follow the power-up edge, and again at the third, where ready must have returned.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
    localparam int NBANK     = 8;
    localparam int WORD_W    = 32;
    localparam int MIN_WORDS = 16;
    localparam int LEN_W     = 16;
    localparam int WAKE_CYC  = 2;

    localparam int BANK_W      = $clog2(NBANK);
    localparam int ADDR_W      = $clog2(MIN_WORDS) + NBANK - 1;
    localparam int DEPTH       = MIN_WORDS << (NBANK - 1);
    localparam int MIN_BYTES   = MIN_WORDS * (WORD_W / 8);
    localparam int TOTAL_BYTES = DEPTH * (WORD_W / 8);
    localparam int CNT_W       = $clog2(WAKE_CYC + 1);

    typedef logic [NBANK-1:0] bank_mask_t;

    function automatic bank_mask_t mask_for_len(input logic [LEN_W-1:0] len);
        bank_mask_t m;
        logic       done;
        m    = '1;
        done = 1'b0;
        for (int n = 1; n <= NBANK; n++) begin
            if (!done && (int'(len) <= (MIN_BYTES << (n - 1)))) begin
                m    = NBANK'((1 << n) - 1);
                done = 1'b1;
            end
        end
        return m;
    endfunction

    function automatic logic [BANK_W-1:0] bank_of_addr(input logic [ADDR_W-1:0] a);
        logic [BANK_W-1:0] b;
        b = '0;
        for (int k = 1; k < NBANK; k++) begin
            if (int'(a) >= (MIN_WORDS << (k - 1)))
                b = BANK_W'(k);
        end
        return b;
    endfunction
endpackage

// File: rtl/pgbuf_sizer.sv
module pgbuf_sizer
    import pgbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hdr_valid,
    input  logic [LEN_W-1:0] hdr_len,
    output bank_mask_t       mask_nxt,
    output bank_mask_t       pwr_en,
    output logic             ovf
);
    assign mask_nxt = mask_for_len(hdr_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_en <= bank_mask_t'(1);
            ovf    <= 1'b0;
        end else if (hdr_valid) begin
            pwr_en <= mask_nxt;
            ovf    <= int'(hdr_len) > TOTAL_BYTES;
        end
    end
endmodule

// File: rtl/pgbuf_wake.sv
module pgbuf_wake
    import pgbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  bank_mask_t mask_nxt,
    input  bank_mask_t pwr_en,
    output bank_mask_t waking
);
    for (genvar k = 0; k < NBANK; k++) begin : g_bank
        logic [CNT_W-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst)
                cnt <= '0;
            else if (load && !mask_nxt[k])
                cnt <= '0;
            else if (load && mask_nxt[k] && !pwr_en[k])
                cnt <= CNT_W'(WAKE_CYC);
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
        assign waking[k] = (cnt != '0);
    end
endmodule

// File: rtl/pgbuf_store.sv
module pgbuf_store
    import pgbuf_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
        if (re)
            rdata <= mem[addr];
    end
endmodule

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
    import pgbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_valid,
    input  logic [LEN_W-1:0]  hdr_len,
    input  logic              acc_valid,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [WORD_W-1:0] acc_wdata,
    output logic              acc_ready,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              acc_err,
    output logic [NBANK-1:0]  bank_pwr_en,
    output logic              len_ovf
);
    bank_mask_t        mask_nxt;
    bank_mask_t        pwr_en;
    bank_mask_t        waking;
    logic [BANK_W-1:0] acc_bank;
    logic              bank_on;
    logic              fire;
    logic              rd_zero_q;
    logic [WORD_W-1:0] mem_q;

    pgbuf_sizer u_sizer (
        .clk      (clk),
        .rst      (rst),
        .hdr_valid(hdr_valid),
        .hdr_len  (hdr_len),
        .mask_nxt (mask_nxt),
        .pwr_en   (pwr_en),
        .ovf      (len_ovf)
    );

    pgbuf_wake u_wake (
        .clk     (clk),
        .rst     (rst),
        .load    (hdr_valid),
        .mask_nxt(mask_nxt),
        .pwr_en  (pwr_en),
        .waking  (waking)
    );

    assign acc_bank  = bank_of_addr(acc_addr);
    assign bank_on   = pwr_en[acc_bank];
    assign acc_ready = !waking[acc_bank];
    assign fire      = acc_valid && acc_ready;

    pgbuf_store u_store (
        .clk  (clk),
        .we   (fire && acc_we && bank_on),
        .re   (fire && !acc_we && bank_on),
        .addr (acc_addr),
        .wdata(acc_wdata),
        .rdata(mem_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid  <= 1'b0;
            acc_err   <= 1'b0;
            rd_zero_q <= 1'b0;
        end else begin
            rd_valid  <= fire && !acc_we;
            acc_err   <= fire && !bank_on;
            rd_zero_q <= !bank_on;
        end
    end

    assign rd_data     = (rd_valid && !rd_zero_q) ? mem_q : '0;
    assign bank_pwr_en = pwr_en;
endmodule

// File: rtl/pgbuf_ctrl_chk.sv
module pgbuf_ctrl_chk
    import pgbuf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_we,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_ready,
    input logic              rd_valid,
    input logic [WORD_W-1:0] rd_data,
    input logic              acc_err,
    input logic [NBANK-1:0]  bank_pwr_en,
    input logic              len_ovf
);
    logic [NBANK-1:0]  prev_pwr;
    logic [BANK_W-1:0] b;
    assign b = bank_of_addr(acc_addr);

    always_ff @(posedge clk) begin
        if (rst) prev_pwr <= NBANK'(1);
        else     prev_pwr <= bank_pwr_en;
    end

    AST_PREFIX_MASK: assert property (@(posedge clk) disable iff (rst)
        ((bank_pwr_en + 1'b1) & bank_pwr_en) == '0); // R2
    AST_BANK0_ON: assert property (@(posedge clk) disable iff (rst)
        bank_pwr_en[0]); // R3
    AST_OVF_SAT: assert property (@(posedge clk) disable iff (rst)
        len_ovf |-> bank_pwr_en == '1); // R4
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_ready && !acc_we) |=> rd_valid); // R6
    AST_ERR_OFF: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_ready && !bank_pwr_en[b]) |=> acc_err); // R7
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc_err && rd_valid) |-> rd_data == '0); // R7
    AST_WAKE_STALL: assert property (@(posedge clk) disable iff (rst)
        (bank_pwr_en[b] && !prev_pwr[b]) |-> !acc_ready); // R8
    AST_NO_ERR_ON: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_ready && bank_pwr_en[b]) |=> !acc_err); // R9
endmodule

bind pgbuf_ctrl pgbuf_ctrl_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_we     (acc_we),
    .acc_addr   (acc_addr),
    .acc_ready  (acc_ready),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .acc_err    (acc_err),
    .bank_pwr_en(bank_pwr_en),
    .len_ovf    (len_ovf)
);

// File: tb/pgbuf_ctrl_tb_top.sv
module pgbuf_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hdr_valid = 1'b0;
    logic [15:0] hdr_len = '0;
    logic        acc_valid = 1'b0;
    logic        acc_we = 1'b0;
    logic [10:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_ready, rd_valid, acc_err, len_ovf;
    logic [31:0] rd_data;
    logic [7:0]  bank_pwr_en;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pgbuf_ctrl dut_i (
        .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_len(hdr_len),
        .acc_valid(acc_valid), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_ready(acc_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .acc_err(acc_err), .bank_pwr_en(bank_pwr_en),
        .len_ovf(len_ovf)
    );

    // {length, expected mask, expected overflow}
    localparam int NV = 14;
    localparam logic [24:0] VEC [NV] = '{
        {16'd0,     8'h01, 1'b0}, {16'd1,    8'h01, 1'b0},
        {16'd64,    8'h01, 1'b0}, {16'd65,   8'h03, 1'b0},
        {16'd128,   8'h03, 1'b0}, {16'd129,  8'h07, 1'b0},
        {16'd512,   8'h0F, 1'b0}, {16'd1000, 8'h1F, 1'b0},
        {16'd4096,  8'h7F, 1'b0}, {16'd4097, 8'hFF, 1'b0},
        {16'd8193,  8'hFF, 1'b1}, {16'd8192, 8'hFF, 1'b0},
        {16'd65535, 8'hFF, 1'b1}, {16'd64,   8'h01, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_hdr(input logic [15:0] len);
        @(negedge clk);
        hdr_valid = 1'b1;
        hdr_len   = len;
        @(posedge clk);
        @(negedge clk);
        hdr_valid = 1'b0;
    endtask

    task automatic do_acc(input logic we, input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_we    = we;
        acc_addr  = a;
        acc_wdata = d;
        #1;
        while (!acc_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 mask", 32'(bank_pwr_en), 32'h01);
        chk("R1 ovf", 32'(len_ovf), 0);
        chk("R1 rd_valid", 32'(rd_valid), 0);
        chk("R1 err", 32'(acc_err), 0);

        // R2 R3 R4 table of lengths
        for (int i = 0; i < NV; i++) begin
            send_hdr(VEC[i][24:9]);
            chk("R2 mask", 32'(bank_pwr_en), 32'(VEC[i][8:1]));
            chk("R4 ovf", 32'(len_ovf), 32'(VEC[i][0]));
        end

        // R8 wake-up stall: mask 0x01 -> 0xFF
        send_hdr(16'd8192);
        acc_addr = 11'd1024; #1;
        chk("R8 stall cycle 1", 32'(acc_ready), 0);
        acc_addr = 11'd0; #1;
        chk("R8 old bank ready", 32'(acc_ready), 1);
        @(negedge clk);
        acc_addr = 11'd1024; #1;
        chk("R8 stall cycle 2", 32'(acc_ready), 0);
        @(negedge clk);
        #1;
        chk("R8 ready after wake", 32'(acc_ready), 1);

        // R5 R6 R9 writes and reads across bank edges
        do_acc(1'b1, 11'd15,   32'h1111_0015);
        chk("R9 no err on write", 32'(acc_err), 0);
        do_acc(1'b1, 11'd16,   32'h2222_0016);
        do_acc(1'b1, 11'd100,  32'hAAAA_0100);
        do_acc(1'b1, 11'd2047, 32'hFFFF_2047);
        do_acc(1'b0, 11'd15, '0);
        chk("R6 rd_valid", 32'(rd_valid), 1);
        chk("R6 data 15", rd_data, 32'h1111_0015);
        do_acc(1'b0, 11'd16, '0);
        chk("R6 data 16", rd_data, 32'h2222_0016);
        do_acc(1'b0, 11'd2047, '0);
        chk("R6 data 2047", rd_data, 32'hFFFF_2047);
        chk("R9 no err on read", 32'(acc_err), 0);
        @(negedge clk);
        chk("R6 rd_valid one cycle", 32'(rd_valid), 0);

        // R5 R7 shrink to 0x07 (words 0..63)
        send_hdr(16'd256);
        chk("R2 mask 256", 32'(bank_pwr_en), 32'h07);
        do_acc(1'b0, 11'd63, '0);
        chk("R5 addr 63 in bank 2", 32'(acc_err), 0);
        do_acc(1'b0, 11'd64, '0);
        chk("R5 addr 64 in bank 3", 32'(acc_err), 1);
        do_acc(1'b1, 11'd100, 32'h5555_0100);
        chk("R7 err on off write", 32'(acc_err), 1);
        do_acc(1'b0, 11'd100, '0);
        chk("R7 err on off read", 32'(acc_err), 1);
        chk("R7 off read zero", rd_data, 0);
        send_hdr(16'd8192);
        repeat (3) @(negedge clk);
        do_acc(1'b0, 11'd100, '0);
        chk("R7 write dropped", rd_data, 32'hAAAA_0100);
        chk("R9 err clear", 32'(acc_err), 0);

        // R1 reset again mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mask after reset", 32'(bank_pwr_en), 32'h01);
        chk("R1 ovf after reset", 32'(len_ovf), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule